// File: doc/BRIEF.md
# Full-Chip Flash Erase Sequencer

This block is a host-side controller that erases a whole byte-wide flash through the flash's command interface. When `start` is raised it turns on the programming-voltage enable. It then writes 00H into every byte, because erasure needs every byte at a known programmed level first. After that it runs erase pulses and checks the result after each pulse. Each pulse is a pair of erase command writes followed by a long settle delay. Each check writes the verify command at the current address, waits a short settle time and reads the byte back.

Addresses are verified in ascending order. A byte that reads FFH lets the sequencer move on to the next address with no further pulse. Any other value causes one more pulse, and verification then continues at the same address. A counter bounds the number of pulses. On both success and failure the sequencer writes the read command 00H, drops the voltage enable and raises `done` or `fail` for one clock. All delays are cycle counts derived from the clock frequency in MHz and the delay lengths in microseconds.

Top module: `erase_seq`

## Requirements
- R1: After `start`, each byte from address 0 to the last address gets a program-setup write (40H) and then a data write of 00H at that address. Each data write is followed by at least CLK_MHZ*PROG_US idle cycles. All of this finishes before the first erase command.
- R2: An erase pulse is two consecutive writes of 20H. Every byte the flash reports as erased afterwards reads FFH.
- R3: At least CLK_MHZ*ERASE_US cycles separate the second 20H write from the next verify-command write (A0H).
- R4: The read strobe `f_oe` comes at least CLK_MHZ*VERIFY_US cycles after the A0H write, at the address of that A0H write, and never in the cycle right after a write.
- R5: Verification starts at address 0 after the first pulse. A read of FFH moves to the next address with no erase pulse in between.
- R6: A read other than FFH causes a new erase pulse, and verification then continues at the same address.
- R7: When a read fails after the MAX_PULSES-th pulse, no further pulse is issued and `fail` rises. `done` and `fail` are never high together.
- R8: The sequence ends with a write of 00H. In the next cycle `vpp_en` is low and `done` (or `fail`) is high for exactly one cycle.
- R9: Every write happens with `vpp_en` and `f_ce` high. `f_we` and `f_oe` are never high together.
- R10: During and right after reset, `f_we`, `f_oe`, `f_ce`, `vpp_en`, `done` and `fail` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a chip erase (sampled while idle) |
| done | output | 1 | One-cycle pulse: erase succeeded |
| fail | output | 1 | One-cycle pulse: pulse limit reached |
| f_addr | output | ADDR_W | Flash address |
| f_dout | output | 8 | Write data / command byte to flash |
| f_din | input | 8 | Read data from flash |
| f_we | output | 1 | Write strobe, one cycle per write |
| f_oe | output | 1 | Read strobe; f_din sampled at the end of the cycle |
| f_ce | output | 1 | Flash chip enable, high while a sequence runs |
| vpp_en | output | 1 | Programming-voltage enable |

## Verification
Bus safety is checked by assertions on every cycle: writes happen only under voltage and chip enable, strobes never overlap, and no read directly follows a write. The end of a run is also checked on every cycle: the final 00H write, the dropped voltage enable, a single-cycle exclusive outcome. Only the bench's flash model can show the rest. That covers the preprogramming of every byte, the delay lengths, the address order of verification and the resume-in-place after a pulse. It also covers the exact pulse and read counts and the failure at the pulse limit. The model gives each byte a different number of pulses it needs before it reads erased.

// File: rtl/erase_seq.sv
module erase_seq #(
  parameter int ADDR_W     = 16,
  parameter int CLK_MHZ    = 250,
  parameter int PROG_US    = 10,
  parameter int ERASE_US   = 10000,
  parameter int VERIFY_US  = 6,
  parameter int MAX_PULSES = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              done,
  output logic              fail,
  output logic [ADDR_W-1:0] f_addr,
  output logic [7:0]        f_dout,
  input  logic [7:0]        f_din,
  output logic              f_we,
  output logic              f_oe,
  output logic              f_ce,
  output logic              vpp_en
);
  localparam int T_PROG  = CLK_MHZ * PROG_US;
  localparam int T_ERASE = CLK_MHZ * ERASE_US;
  localparam int T_VER   = CLK_MHZ * VERIFY_US;
  localparam int T_MAX   = (T_ERASE > T_PROG) ? ((T_ERASE > T_VER) ? T_ERASE : T_VER)
                                              : ((T_PROG > T_VER) ? T_PROG : T_VER);
  localparam int TW = $clog2(T_MAX + 1);
  localparam int PW = $clog2(MAX_PULSES + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_PSET, S_PDAT, S_PWAIT, S_ESET, S_ECMD, S_EWAIT,
    S_VCMD, S_VWAIT, S_VRD, S_EXIT, S_END
  } st_t;

  st_t             st;
  logic [ADDR_W-1:0] addr;
  logic [TW-1:0]   tmr;
  logic [PW-1:0]   pcnt;
  logic            err;
  logic            last;

  assign last   = &addr;
  assign f_addr = addr;
  assign f_we   = (st == S_PSET) || (st == S_PDAT) || (st == S_ESET) ||
                  (st == S_ECMD) || (st == S_VCMD) || (st == S_EXIT);
  assign f_oe   = (st == S_VRD);
  assign f_ce   = (st != S_IDLE) && (st != S_END);
  assign vpp_en = f_ce;
  assign done   = (st == S_END) && !err;
  assign fail   = (st == S_END) && err;

  always_comb begin
    case (st)
      S_PSET:         f_dout = 8'h40;
      S_ESET, S_ECMD: f_dout = 8'h20;
      S_VCMD:         f_dout = 8'hA0;
      default:        f_dout = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      addr <= '0;
      tmr  <= '0;
      pcnt <= '0;
      err  <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          addr <= '0;
          err  <= 1'b0;
          st   <= S_PSET;
        end
        S_PSET: st <= S_PDAT;
        S_PDAT: begin
          tmr <= TW'(T_PROG - 1);
          st  <= S_PWAIT;
        end
        S_PWAIT: begin
          if (tmr != '0) tmr <= tmr - 1'b1;
          else if (last) begin
            addr <= '0;
            pcnt <= '0;
            st   <= S_ESET;
          end else begin
            addr <= addr + 1'b1;
            st   <= S_PSET;
          end
        end
        S_ESET: st <= S_ECMD;
        S_ECMD: begin
          tmr <= TW'(T_ERASE - 1);
          st  <= S_EWAIT;
        end
        S_EWAIT: begin
          if (tmr != '0) tmr <= tmr - 1'b1;
          else st <= S_VCMD;
        end
        S_VCMD: begin
          tmr <= TW'(T_VER - 1);
          st  <= S_VWAIT;
        end
        S_VWAIT: begin
          if (tmr != '0) tmr <= tmr - 1'b1;
          else st <= S_VRD;
        end
        S_VRD: begin
          if (f_din == 8'hFF) begin
            if (last) st <= S_EXIT;
            else begin
              addr <= addr + 1'b1;
              st   <= S_VCMD;
            end
          end else if (pcnt == PW'(MAX_PULSES - 1)) begin
            err <= 1'b1;
            st  <= S_EXIT;
          end else begin
            pcnt <= pcnt + 1'b1;
            st   <= S_ESET;
          end
        end
        S_EXIT: st <= S_END;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/erase_seq_chk.sv
module erase_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       done,
  input logic       fail,
  input logic [7:0] f_dout,
  input logic       f_we,
  input logic       f_oe,
  input logic       f_ce,
  input logic       vpp_en
);
  a_r9_write_needs_vpp: assert property (@(posedge clk) disable iff (!rst_n)
    f_we |-> (vpp_en && f_ce));

  a_r9_no_bus_clash: assert property (@(posedge clk) disable iff (!rst_n)
    !(f_we && f_oe));

  a_r4_read_after_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    f_oe |-> !$past(f_we));

  a_r7_single_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fail));

  a_r8_exit_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fail) |-> ($past(f_we) && $past(f_dout) == 8'h00 && !vpp_en));

  a_r8_outcome_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fail) |=> !(done || fail));

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !vpp_en |-> (!f_we && !f_oe && !f_ce));
endmodule

bind erase_seq erase_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .fail(fail), .f_dout(f_dout),
  .f_we(f_we), .f_oe(f_oe), .f_ce(f_ce), .vpp_en(vpp_en)
);

// File: tb/sim_erase_seq.sv
`timescale 1ns/1ps
module sim_erase_seq;
  localparam int AW = 4;
  localparam int N = 1 << AW;
  localparam int MHZ = 1;
  localparam int PUS = 10;
  localparam int EUS = 40;
  localparam int VUS = 6;
  localparam int MAXP = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic done, fail, f_we, f_oe, f_ce, vpp_en;
  logic [AW-1:0] f_addr;
  logic [7:0] f_dout, f_din;

  always #2 clk = ~clk;

  erase_seq #(.ADDR_W(AW), .CLK_MHZ(MHZ), .PROG_US(PUS), .ERASE_US(EUS),
              .VERIFY_US(VUS), .MAX_PULSES(MAXP)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done), .fail(fail),
    .f_addr(f_addr), .f_dout(f_dout), .f_din(f_din), .f_we(f_we),
    .f_oe(f_oe), .f_ce(f_ce), .vpp_en(vpp_en));

  logic [7:0] mem [N];
  int need [N];
  int mode;
  int cyc, pulses, reads, progs, viol, gap_p, gap_e, gap_v, ordbad, modebad;
  int last_prog, last_er, last_ev, ev_addr, exp_addr;
  bit first_er, pre_ok;
  logic [7:0] lastw;
  int nchk = 0, nbad = 0;

  assign f_din = mem[f_addr];

  always @(negedge clk) begin
    cyc++;
    if (f_we) begin
      lastw = f_dout;
      if (!vpp_en || !f_ce) viol++;
      if (mode == 1) begin
        mem[f_addr] = mem[f_addr] & f_dout;
        progs++;
        last_prog = cyc;
        mode = 0;
      end else if (f_dout == 8'h40) begin
        if (last_prog >= 0 && cyc - last_prog < MHZ*PUS) gap_p++;
        mode = 1;
      end else if (f_dout == 8'h20) begin
        if (mode == 2) begin
          if (first_er) begin
            first_er = 0;
            if (last_prog >= 0 && cyc - last_prog < MHZ*PUS) gap_p++;
            for (int i = 0; i < N; i++) if (mem[i] != 8'h00) pre_ok = 0;
          end
          pulses++;
          for (int i = 0; i < N; i++) if (pulses >= need[i]) mem[i] = 8'hFF;
          last_er = cyc;
          mode = 0;
        end else mode = 2;
      end else if (f_dout == 8'hA0) begin
        if (cyc - last_er < MHZ*EUS) gap_e++;
        last_ev = cyc;
        ev_addr = int'(f_addr);
        mode = 3;
      end else mode = 0;
    end
    if (f_oe) begin
      reads++;
      if (mode != 3) modebad++;
      if (cyc - last_ev < MHZ*VUS) gap_v++;
      if (int'(f_addr) != ev_addr || int'(f_addr) != exp_addr) ordbad++;
      if (mem[f_addr] == 8'hFF) exp_addr++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic void predict(output int xp, output int xr, output bit xf);
    int p = 1;
    xr = 0; xf = 0;
    for (int a = 0; a < N; a++) begin
      while (1) begin
        xr++;
        if (need[a] <= p) break;
        if (p == MAXP) begin
          xf = 1; xp = p; return;
        end
        p++;
      end
    end
    xp = p;
  endfunction

  task automatic run(input string tag);
    int xp, xr;
    bit xf, ended;
    predict(xp, xr, xf);
    mode = 0; pulses = 0; reads = 0; progs = 0; viol = 0;
    gap_p = 0; gap_e = 0; gap_v = 0; ordbad = 0; modebad = 0;
    last_prog = -1; last_er = 0; last_ev = 0; ev_addr = -1; exp_addr = 0;
    first_er = 1; pre_ok = 1; lastw = 8'h55;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    ended = 0;
    for (int i = 0; i < 60000; i++) begin
      if (done || fail) begin ended = 1; break; end
      @(negedge clk);
    end
    check(ended, {"R7 watchdog ", tag}, 0, 1);
    if (!ended) return;
    $display("%s: pulses=%0d reads=%0d fail=%0d", tag, pulses, reads, fail);
    check(fail == xf && done == !xf, {"R7 outcome ", tag}, int'(fail), int'(xf));
    check(pulses == xp, {"R6 pulse count ", tag}, pulses, xp);
    check(reads == xr, {"R5 read count ", tag}, reads, xr);
    check(ordbad == 0 && modebad == 0, {"R6 verify order ", tag}, ordbad + modebad, 0);
    check(pre_ok && progs == N, {"R1 preprogram ", tag}, progs, N);
    check(gap_p == 0, {"R1 program wait ", tag}, gap_p, 0);
    check(gap_e == 0, {"R3 erase wait ", tag}, gap_e, 0);
    check(gap_v == 0, {"R4 verify wait ", tag}, gap_v, 0);
    check(viol == 0, {"R9 write without vpp ", tag}, viol, 0);
    check(!vpp_en && lastw == 8'h00 && mode == 0, {"R8 exit ", tag}, int'(lastw), 0);
    if (!xf) begin
      int nff = 0;
      for (int i = 0; i < N; i++) if (mem[i] == 8'hFF) nff++;
      check(nff == N, {"R2 all erased ", tag}, nff, N);
    end
    @(negedge clk);
    check(!done && !fail, {"R8 one-cycle outcome ", tag}, int'(done | fail), 0);
  endtask

  task automatic fill_rand();
    for (int i = 0; i < N; i++) mem[i] = 8'($urandom);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < N; i++) begin mem[i] = 8'hA5; need[i] = 1; end
    repeat (3) @(negedge clk);
    check(!f_we && !f_oe && !f_ce && !vpp_en && !done && !fail, "R10 reset", 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!f_we && !f_oe && !f_ce && !vpp_en && !done && !fail, "R10 after reset", 0, 0);

    fill_rand();
    for (int i = 0; i < N; i++) need[i] = 1;
    run("one pulse");

    fill_rand();
    for (int i = 0; i < N; i++) need[i] = (i % MAXP) + 1;
    run("ramp");

    fill_rand();
    for (int i = 0; i < N; i++) need[i] = 1;
    need[N-1] = MAXP;
    run("limit exact");

    fill_rand();
    for (int i = 0; i < N; i++) need[i] = 2;
    need[5] = MAXP + 1;
    run("limit exceeded");

    for (int r = 0; r < 5; r++) begin
      fill_rand();
      for (int i = 0; i < N; i++)
        need[i] = (($urandom % 24) == 0) ? MAXP + 1 : int'($urandom % MAXP) + 1;
      run("random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule